// File: doc/BRIEF.md
# Passive Matrix Row Scanner with Brightness Gating

This block sequences a 20 by 20 LED array in which every row shares one cathode line and every column shares one anode line. Only one row line is pulled low at a time. The block walks through the rows in ascending order and wraps back to the first row. While a row is selected, the block drives its 20 anode lines from that row's pixel word, which it reads from an external frame store.

Every row occupies a slot of 16 clock cycles, so a full frame takes 320 cycles. The refresh rate therefore follows the clock directly: at 1 MHz one frame lasts 320 us. A 4-bit phase counter runs inside each slot. When brightness gating is enabled, a lit column is driven only while that phase is below a 4-bit brightness value. When gating is disabled, a lit column is driven for the whole slot.

The block asks the frame store for the next row's word one cycle before that row's slot begins. A one-cycle frame marker lets the logic that writes the store line its updates up with the start of a frame. After reset is released the block waits a fixed three-cycle startup interval before the first row lights.

Top module: `pmxScanDrive`

## Requirements
- R1: While `rstN` is low, asynchronously and independent of the clock, every bit of `rowEnN` is 1, `colDrive` is 0, `frameStart` is 0 and `pixRdAddr` is 0.
- R2: After `rstN` rises, `rowEnN` stays all ones and `colDrive` stays 0 through the first two rising clock edges. After the third rising edge, row 0 is selected (`rowEnN[0]` is 0), which is phase 0 of its slot.
- R3: Once running, exactly one bit of `rowEnN` is 0, and bit i being 0 selects row i. The selected row advances by one every 16 clock cycles and wraps from row 19 to row 0, so a frame lasts 320 cycles.
- R4: `pixRdAddr` equals the selected row index in phases 0 to 14 of a slot. In phase 15 it equals the index of the following row, wrapping from 19 to 0. Before the first slot it is 0.
- R5: With `pwmEnable` high, `colDrive[c]` is 1 exactly when bit c of `pixRdData` is 1 and the slot phase is less than `brightness`. A brightness of 0 keeps every column dark, and 15 drives lit columns in 15 of the 16 phases.
- R6: With `pwmEnable` low, `colDrive[c]` equals bit c of `pixRdData` in all 16 phases of a slot, whatever `brightness` holds.
- R7: `frameStart` is 1 in exactly one cycle per frame: phase 0 of the slot of row 0.
- R8: `colDrive` is 0 in every cycle in which no row is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pwmEnable | input | 1 | 1 = gate columns by brightness, 0 = drive for the whole slot |
| brightness | input | 4 | Number of phases per slot in which lit columns conduct |
| pixRdData | input | 20 | Pixel word of the requested row, bit c = column c |
| pixRdAddr | output | 5 | Row index requested from the frame store |
| rowEnN | output | 20 | Cathode selects, active low, bit i = row i |
| colDrive | output | 20 | Anode drives, active high, bit c = column c |
| frameStart | output | 1 | One-cycle marker at the start of row 0 |

## Verification
Three events fall in the same cycle. The last phase of row 19 is the cycle in which the row index wraps and the store address jumps back to 0. The next cycle raises the frame marker while the brightness gate reopens at phase 0. The bench runs whole frames while it steps the brightness through all sixteen values and then switches gating off, so every wrap coincides with each gate setting. In every cycle it compares each output with values derived from the count of edges since reset release. A reset asserted in the middle of a frame, followed by a fresh startup, checks that the wrap state and the delay counter both start clean.

// File: rtl/pmxScanPkg.sv
package pmxScanPkg;

  // Strobes from the slot sequencer to the row/column datapath
  typedef struct packed {
    logic run;        // scanning active (startup delay elapsed)
    logic slotFirst;  // first phase of a row slot
    logic slotLast;   // last phase of a row slot
  } scanStrobe_t;

endpackage

// File: rtl/pmxScanCtrl.sv
module pmxScanCtrl
  import pmxScanPkg::*;
#(
  parameter int SLOT_W      = 4,
  parameter int START_DELAY = 3
) (
  input  logic              clk,
  input  logic              rstN,
  output scanStrobe_t       strb,
  output logic [SLOT_W-1:0] phase
);

  localparam int DLY_W = (START_DELAY < 2) ? 1 : $clog2(START_DELAY + 1);
  localparam logic [DLY_W-1:0]  DLY_LAST   = DLY_W'(START_DELAY - 1);
  localparam logic [SLOT_W-1:0] PHASE_LAST = '1;

  logic [DLY_W-1:0] dlyCnt;
  logic             run;

  // Startup delay followed by a free-running phase counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlyCnt <= '0;
      run    <= 1'b0;
      phase  <= '0;
    end else if (!run) begin
      if (dlyCnt == DLY_LAST) begin
        run <= 1'b1;
      end else begin
        dlyCnt <= dlyCnt + 1'b1;
      end
    end else begin
      phase <= phase + 1'b1;
    end
  end

  always_comb begin
    strb.run       = run;
    strb.slotFirst = run && (phase == '0);
    strb.slotLast  = run && (phase == PHASE_LAST);
  end

endmodule

// File: rtl/pmxScanData.sv
module pmxScanData
  import pmxScanPkg::*;
#(
  parameter int NUM_ROWS = 20,
  parameter int NUM_COLS = 20,
  parameter int SLOT_W   = 4,
  parameter int ROW_W    = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  scanStrobe_t         strb,
  input  logic [SLOT_W-1:0]   phase,
  input  logic                pwmEnable,
  input  logic [SLOT_W-1:0]   brightness,
  input  logic [NUM_COLS-1:0] pixRdData,
  output logic [ROW_W-1:0]    pixRdAddr,
  output logic [NUM_ROWS-1:0] rowEnN,
  output logic [NUM_COLS-1:0] colDrive,
  output logic                frameStart
);

  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(NUM_ROWS - 1);

  logic [ROW_W-1:0] rowIdx;
  logic [ROW_W-1:0] nextRow;
  logic             pwmGate;

  assign nextRow = (rowIdx == ROW_LAST) ? '0 : rowIdx + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowIdx <= '0;
    end else if (strb.slotLast) begin
      rowIdx <= nextRow;
    end
  end

  // Store address runs one cycle ahead of the slot boundary
  assign pixRdAddr  = strb.slotLast ? nextRow : rowIdx;
  assign frameStart = strb.slotFirst && (rowIdx == '0);
  assign pwmGate    = !pwmEnable || (phase < brightness);

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_rowSel
    assign rowEnN[r] = ~(strb.run && (rowIdx == ROW_W'(r)));
  end

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_colDrv
    assign colDrive[c] = strb.run && pwmGate && pixRdData[c];
  end

endmodule

// File: rtl/pmxScanDrive.sv
module pmxScanDrive
  import pmxScanPkg::*;
#(
  parameter int NUM_ROWS    = 20,
  parameter int NUM_COLS    = 20,
  parameter int SLOT_W      = 4,
  parameter int START_DELAY = 3,
  localparam int ROW_W      = $clog2(NUM_ROWS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pwmEnable,
  input  logic [SLOT_W-1:0]   brightness,
  input  logic [NUM_COLS-1:0] pixRdData,
  output logic [ROW_W-1:0]    pixRdAddr,
  output logic [NUM_ROWS-1:0] rowEnN,
  output logic [NUM_COLS-1:0] colDrive,
  output logic                frameStart
);

  scanStrobe_t       strb;
  logic [SLOT_W-1:0] phase;

  pmxScanCtrl #(
    .SLOT_W     (SLOT_W),
    .START_DELAY(START_DELAY)
  ) uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .strb (strb),
    .phase(phase)
  );

  pmxScanData #(
    .NUM_ROWS(NUM_ROWS),
    .NUM_COLS(NUM_COLS),
    .SLOT_W  (SLOT_W),
    .ROW_W   (ROW_W)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .phase     (phase),
    .pwmEnable (pwmEnable),
    .brightness(brightness),
    .pixRdData (pixRdData),
    .pixRdAddr (pixRdAddr),
    .rowEnN    (rowEnN),
    .colDrive  (colDrive),
    .frameStart(frameStart)
  );

endmodule

// File: rtl/pmxScanChecker.sv
module pmxScanChecker
  import pmxScanPkg::*;
#(
  parameter int NUM_ROWS = 20,
  parameter int NUM_COLS = 20,
  parameter int SLOT_W   = 4,
  parameter int ROW_W    = 5
) (
  input logic                clk,
  input logic                rstN,
  input scanStrobe_t         strb,
  input logic                pwmEnable,
  input logic [SLOT_W-1:0]   brightness,
  input logic [ROW_W-1:0]    pixRdAddr,
  input logic [NUM_ROWS-1:0] rowEnN,
  input logic [NUM_COLS-1:0] colDrive,
  input logic                frameStart
);

  localparam logic [NUM_ROWS-1:0] ROW_ONE = NUM_ROWS'(1);

  // R1: reset keeps the array dark
  p_reset_dark_r1: assert property (@(posedge clk)
    !rstN |-> ((&rowEnN) && (colDrive == '0) && !frameStart));

  // R2: scanning starts only after three edges of released reset
  p_late_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.run) |-> ($past(rstN, 1) && $past(rstN, 2)));

  // R3: never more than one cathode selected
  p_one_row_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~rowEnN));

  // R3: rows hold their selection within a slot
  p_row_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && $past(strb.run) && !$past(strb.slotLast)) |-> $stable(rowEnN));

  // R4: the row requested at the slot end is the row selected next
  p_addr_ahead_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.slotLast |=> (rowEnN == ~(ROW_ONE << $past(pixRdAddr))));

  // R5: zero brightness gives a dark array
  p_dark_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pwmEnable && (brightness == '0)) |-> (colDrive == '0));

  // R7: the frame marker coincides with row 0
  p_frame_row0_r7: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> !rowEnN[0]);

  // R8: no anode drive while no row is selected
  p_idle_cols_r8: assert property (@(posedge clk) disable iff (!rstN)
    (&rowEnN) |-> (colDrive == '0));

endmodule

bind pmxScanDrive pmxScanChecker #(
  .NUM_ROWS(NUM_ROWS),
  .NUM_COLS(NUM_COLS),
  .SLOT_W  (SLOT_W),
  .ROW_W   (ROW_W)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .strb      (strb),
  .pwmEnable (pwmEnable),
  .brightness(brightness),
  .pixRdAddr (pixRdAddr),
  .rowEnN    (rowEnN),
  .colDrive  (colDrive),
  .frameStart(frameStart)
);

// File: tb/pmxScanDrive_test.sv
`timescale 1ns/1ps
module pmxScanDrive_test;

  localparam int ROWS  = 20;
  localparam int COLS  = 20;
  localparam int ROW_W = 5;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             pwmEnable = 1'b1;
  logic [3:0]       brightness = 4'd0;
  logic [COLS-1:0]  pixRdData = '0;
  logic [ROW_W-1:0] pixRdAddr;
  logic [ROWS-1:0]  rowEnN;
  logic [COLS-1:0]  colDrive;
  logic             frameStart;

  int compared = 0;
  int mismatched = 0;
  int edgeCnt = 0;
  logic [31:0] seed = 32'h0;

  always #5 clk = ~clk;

  pmxScanDrive uut (
    .clk       (clk),
    .rstN      (rstN),
    .pwmEnable (pwmEnable),
    .brightness(brightness),
    .pixRdData (pixRdData),
    .pixRdAddr (pixRdAddr),
    .rowEnN    (rowEnN),
    .colDrive  (colDrive),
    .frameStart(frameStart)
  );

  function automatic logic [COLS-1:0] pattern(input int r);
    logic [31:0] v;
    v = (32'(r) + 32'd1) * 32'h0009E377 ^ seed;
    if (r == 3) return '1;
    return v[COLS-1:0];
  endfunction

  // synchronous-read frame store model
  always @(posedge clk) pixRdData <= pattern(int'(pixRdAddr));

  // rising edges seen since reset release
  always @(posedge clk or negedge rstN) begin
    if (!rstN) edgeCnt <= 0;
    else       edgeCnt <= edgeCnt + 1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h (edge %0d)", tag, act, exp, edgeCnt);
    end
  endtask

  task automatic checkCycle();
    int t, row, ph;
    logic [ROWS-1:0] expRow;
    logic [COLS-1:0] expCol;
    logic gate;
    if (edgeCnt < 3) begin
      check("R2 rows idle", 32'(rowEnN), 32'(ROWS'('1)));
      check("R8 cols idle", 32'(colDrive), 32'h0);
      check("R4 addr idle", 32'(pixRdAddr), 32'h0);
      check("R7 no marker", 32'(frameStart), 32'h0);
    end else begin
      t   = edgeCnt - 3;
      row = (t / 16) % ROWS;
      ph  = t % 16;
      expRow = ~(ROWS'(1) << row);
      gate   = pwmEnable ? (ph < int'(brightness)) : 1'b1;
      expCol = gate ? pattern(row) : '0;
      check(t < 16 ? "R2 first row" : "R3 row select", 32'(rowEnN), 32'(expRow));
      check(pwmEnable ? "R5 gated cols" : "R6 bypass cols", 32'(colDrive), 32'(expCol));
      check("R4 addr", 32'(pixRdAddr), 32'(ph == 15 ? (row + 1) % ROWS : row));
      check("R7 marker", 32'(frameStart), 32'(row == 0 && ph == 0));
    end
  endtask

  task automatic runCycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checkCycle();
    end
  endtask

  task automatic checkReset();
    check("R1 rows", 32'(rowEnN), 32'(ROWS'('1)));
    check("R1 cols", 32'(colDrive), 32'h0);
    check("R1 marker", 32'(frameStart), 32'h0);
    check("R1 addr", 32'(pixRdAddr), 32'h0);
  endtask

  initial begin
    #1 checkReset();
    repeat (3) @(negedge clk);
    checkReset();
    rstN = 1'b1;
    // R5: brightness sweep, one frame per value
    for (int b = 0; b < 16; b++) begin
      brightness = 4'(b);
      runCycles(b == 0 ? 323 : 320);
    end
    // R6: gating bypass with a brightness that would otherwise darken
    pwmEnable  = 1'b0;
    brightness = 4'd2;
    runCycles(330);
    // R1: asynchronous reset in mid-frame
    #2 rstN = 1'b0;
    #1 checkReset();
    seed = 32'h5A5A3C3C;
    repeat (4) @(negedge clk);
    checkReset();
    rstN = 1'b1;
    pwmEnable  = 1'b1;
    brightness = 4'd9;
    runCycles(700);
    brightness = 4'd15;
    runCycles(330);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 10);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule